// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory and watches the two access ports, named left and right. Each port presents a chip enable, an address and a write request. When both ports are enabled on the same location, the arbiter picks the port that got there first, drives an active-low busy flag to the other port, and blocks that port's write strobe so the losing port cannot modify the location. Reads are never blocked. The busied port's read data is simply not guaranteed while the winner is writing the same word.

A mode input selects how the busy pins behave. In master mode the arbiter makes the decision itself and drives it on the busy outputs. In slave mode the block makes no decision: its busy outputs stay inactive, and externally supplied busy inputs, normally from a master working on the same address range, act only as per-port write inhibits. This lets several instances share one decision when the memory is made wider. Everything is synchronous to one clock. Each port's enable and address are registered every cycle, so the block can tell which port's request is new in the current cycle.

Top module: `dpca_arbiter`

## Requirements
- R1: In master mode, if in the cycle before a clock edge the two enables were not both high, or the two addresses differed, then after that edge both busy outputs are high (inactive).
- R2: The read/write request bits play no part in the decision. A collision of two reads flags the same port as a collision of two writes.
- R3: A request is "new" in a cycle when its enable has just risen or its address has changed while enabled. If only one port's request is new and it matches the other port's standing request, the new port loses, and its busy output goes low after the next clock edge.
- R4: When both requests are new in the same cycle and they collide, the left port wins and the right busy output goes low. The two busy outputs are never low at the same time.
- R5: In master mode, a port's write enable to the array is low whenever that port loses in the current cycle's decision or its busy output is low. Otherwise it equals write request AND chip enable.
- R6: The winner keeps ownership while its request is unchanged. Once the winner drops its enable or moves to another address, the loser's busy output returns high after the next clock edge, and its write enable follows in that same cycle.
- R7: In slave mode (mode input high), both busy outputs are held high. Each port's write enable equals write request AND chip enable AND that port's busy input, where the busy input is active low.
- R8: If the loser leaves the shared address and later returns to it while the winner holds its request, the winner keeps winning and the loser is flagged busy again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_mode | input | 1 | 1 = slave (busy pins are inputs used as write inhibit), 0 = master |
| l_ce | input | 1 | Left port chip enable, active high |
| l_addr | input | ADDR_W (11) | Left port address |
| l_we | input | 1 | Left port write request |
| r_ce | input | 1 | Right port chip enable, active high |
| r_addr | input | ADDR_W (11) | Right port address |
| r_we | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | External busy for the left port, active low, used in slave mode |
| r_busy_in_n | input | 1 | External busy for the right port, active low, used in slave mode |
| l_busy_n | output | 1 | Left port busy flag, active low |
| r_busy_n | output | 1 | Right port busy flag, active low |
| l_wen | output | 1 | Gated left write enable to the array |
| r_wen | output | 1 | Gated right write enable to the array |

## Verification
Two things can fall in the same cycle. One is a pair of new requests arriving together. The other is the decision and the write gating: the write strobe must already be blocked in the cycle the loss is decided, one cycle before the registered busy pin shows it. The bench raises both enables on a shared address on the same falling edge, with both write requests set. It checks the combinational write enables before the next rising edge, expecting the left write enable high and the right one low. After the edge it checks that only the right busy pin is low. The release case is judged the same way: the winner withdraws, and the loser's write stays blocked until the edge that clears its busy pin.

// File: rtl/dpca_pkg.sv
`timescale 1ns/1ps
package dpca_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int SIDE_L    = 0;
   localparam int SIDE_R    = 1;
   localparam int NUM_SIDES = 2;
endpackage

// File: rtl/dpca_port_track.sv
`timescale 1ns/1ps
module dpca_port_track #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [ADDR_W-1:0] addr,
   output logic              fresh
);
   logic              ce_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         ce_q   <= ce;
         addr_q <= addr;
      end
   end

   // a request is new when it just appeared or moved while enabled
   assign fresh = ce && (!ce_q || (addr != addr_q));

   // R3: a request held unchanged for a cycle is never new
   p_stable_not_fresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && $past(ce) && $stable(addr)) |-> !fresh);
endmodule

// File: rtl/dpca_judge.sv
`timescale 1ns/1ps
module dpca_judge
   import dpca_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_ce,
   input  logic              r_ce,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_fresh,
   input  logic              r_fresh,
   output logic              match,
   output owner_e            win_d,
   output owner_e            win_q
);
   assign match = l_ce && r_ce && (l_addr == r_addr);

   always_comb begin
      if (!match) begin
         win_d = OWN_NONE;
      end else if ((win_q == OWN_NONE) || l_fresh || r_fresh) begin
         // the stable side wins; a tie or no history favours left
         if (l_fresh && !r_fresh) win_d = OWN_RIGHT;
         else                     win_d = OWN_LEFT;
      end else begin
         win_d = win_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= OWN_NONE;
      else        win_q <= win_d;
   end

   // R4: two new colliding requests resolve in favour of the left side
   p_tie_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match && l_fresh && r_fresh) |=> (win_q == OWN_LEFT));

   // R8: an unchanged left owner keeps the location
   p_hold_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (match && (win_q == OWN_LEFT) && !l_fresh) |=> (win_q == OWN_LEFT));

   // R8: an unchanged right owner keeps the location
   p_hold_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (match && (win_q == OWN_RIGHT) && !r_fresh) |=> (win_q == OWN_RIGHT));
endmodule

// File: rtl/dpca_wgate.sv
`timescale 1ns/1ps
module dpca_wgate (
   input  logic clk,
   input  logic rst_n,
   input  logic slave_mode,
   input  logic ce,
   input  logic we,
   input  logic lose_now,
   input  logic lose_held,
   input  logic busy_in_n,
   output logic wen
);
   logic inhibit;

   assign inhibit = slave_mode ? !busy_in_n : (lose_now || lose_held);
   assign wen     = ce && we && !inhibit;

   // R5: a port that holds the busy decision never writes
   p_busy_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && lose_held) |-> !wen);

   // R7: an external busy in slave mode blocks the write
   p_slave_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_mode && !busy_in_n) |-> !wen);
endmodule

// File: rtl/dpca_arbiter.sv
`timescale 1ns/1ps
module dpca_arbiter
   import dpca_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode,
   input  logic              l_ce,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_we,
   input  logic              r_ce,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_we,
   input  logic              l_busy_in_n,
   input  logic              r_busy_in_n,
   output logic              l_busy_n,
   output logic              r_busy_n,
   output logic              l_wen,
   output logic              r_wen
);
   localparam int ADDR_MAX = 32;

   if ((ADDR_W < 1) || (ADDR_W > ADDR_MAX)) begin : g_bad_width
      $error("dpca_arbiter: ADDR_W must lie in 1..32");
   end

   logic              ce_v    [NUM_SIDES];
   logic              we_v    [NUM_SIDES];
   logic [ADDR_W-1:0] addr_v  [NUM_SIDES];
   logic              bin_v   [NUM_SIDES];
   logic              fresh_v [NUM_SIDES];
   logic              lnow_v  [NUM_SIDES];
   logic              lheld_v [NUM_SIDES];
   logic              wen_v   [NUM_SIDES];
   logic              match;
   owner_e            win_d, win_q;

   assign ce_v[SIDE_L]   = l_ce;
   assign ce_v[SIDE_R]   = r_ce;
   assign we_v[SIDE_L]   = l_we;
   assign we_v[SIDE_R]   = r_we;
   assign addr_v[SIDE_L] = l_addr;
   assign addr_v[SIDE_R] = r_addr;
   assign bin_v[SIDE_L]  = l_busy_in_n;
   assign bin_v[SIDE_R]  = r_busy_in_n;

   // a side loses when the opposite side owns the location
   assign lnow_v[SIDE_L]  = (win_d == OWN_RIGHT);
   assign lnow_v[SIDE_R]  = (win_d == OWN_LEFT);
   assign lheld_v[SIDE_L] = (win_q == OWN_RIGHT);
   assign lheld_v[SIDE_R] = (win_q == OWN_LEFT);

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      dpca_port_track #(.ADDR_W(ADDR_W)) track_i (
         .clk   (clk),
         .rst_n (rst_n),
         .ce    (ce_v[s]),
         .addr  (addr_v[s]),
         .fresh (fresh_v[s])
      );

      dpca_wgate gate_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .slave_mode (slave_mode),
         .ce         (ce_v[s]),
         .we         (we_v[s]),
         .lose_now   (lnow_v[s]),
         .lose_held  (lheld_v[s]),
         .busy_in_n  (bin_v[s]),
         .wen        (wen_v[s])
      );
   end

   dpca_judge #(.ADDR_W(ADDR_W)) judge_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .l_ce    (l_ce),
      .r_ce    (r_ce),
      .l_addr  (l_addr),
      .r_addr  (r_addr),
      .l_fresh (fresh_v[SIDE_L]),
      .r_fresh (fresh_v[SIDE_R]),
      .match   (match),
      .win_d   (win_d),
      .win_q   (win_q)
   );

   assign l_busy_n = slave_mode || !lheld_v[SIDE_L];
   assign r_busy_n = slave_mode || !lheld_v[SIDE_R];
   assign l_wen    = wen_v[SIDE_L];
   assign r_wen    = wen_v[SIDE_R];

   // R4: both ports are never flagged together
   p_never_both_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!l_busy_n && !r_busy_n));

   // R1: no shared enabled location in the last cycle, no busy now
   p_idle_no_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!slave_mode && $past(!(l_ce && r_ce && (l_addr == r_addr))))
         |-> (l_busy_n && r_busy_n));

   // R7: a slave never drives busy
   p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      slave_mode |-> (l_busy_n && r_busy_n));
endmodule

// File: tb/dpca_arbiter_tb_top.sv
`timescale 1ns/1ps
module dpca_arbiter_tb_top;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slave_mode = 1'b0;
   logic          l_ce = 1'b0, r_ce = 1'b0, l_we = 1'b0, r_we = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
   logic          l_busy_n, r_busy_n, l_wen, r_wen;

   int n_cmp  = 0;
   int n_miss = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dpca_arbiter #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
      .l_ce(l_ce), .l_addr(l_addr), .l_we(l_we),
      .r_ce(r_ce), .r_addr(r_addr), .r_we(r_we),
      .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
      .l_wen(l_wen), .r_wen(r_wen)
   );

   task automatic check(string req, string what, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic check_busy(string req, logic el, logic er);
      check(req, "l_busy_n", l_busy_n, el);
      check(req, "r_busy_n", r_busy_n, er);
   endtask

   task automatic check_wen(string req, logic el, logic er);
      check(req, "l_wen", l_wen, el);
      check(req, "r_wen", r_wen, er);
   endtask

   // drive at a falling edge, settle briefly before the comb checks
   task automatic drive(logic lc, logic [AW-1:0] la, logic lw,
                        logic rc, logic [AW-1:0] ra, logic rw);
      l_ce = lc; l_addr = la; l_we = lw;
      r_ce = rc; r_addr = ra; r_we = rw;
      #1;
   endtask

   // wait through one rising edge to the next falling edge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      drive(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
      tick();
      tick();
   endtask

   task automatic t_reset();
      check_busy("R1 reset", 1'b1, 1'b1);
      check_wen("R1 reset", 1'b0, 1'b0);
   endtask

   task automatic t_no_match();
      drive(1'b1, 11'h010, 1'b1, 1'b1, 11'h011, 1'b1);
      check_wen("R1 distinct", 1'b1, 1'b1);
      tick();
      check_busy("R1 distinct", 1'b1, 1'b1);
      drive(1'b1, 11'h020, 1'b1, 1'b0, 11'h020, 1'b1);
      tick();
      check_busy("R1 one disabled", 1'b1, 1'b1);
      check_wen("R1 one disabled", 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_left_first();
      drive(1'b1, 11'h005, 1'b0, 1'b0, 11'h000, 1'b0);
      tick();
      drive(1'b1, 11'h005, 1'b1, 1'b1, 11'h005, 1'b1);
      check_wen("R5 decision cycle", 1'b1, 1'b0);
      tick();
      check_busy("R3 left first", 1'b1, 1'b0);
      check_wen("R5 while busy", 1'b1, 1'b0);
      drive(1'b0, 11'h005, 1'b0, 1'b1, 11'h005, 1'b1);
      check_wen("R6 release cycle", 1'b0, 1'b0);
      tick();
      check_busy("R6 released", 1'b1, 1'b1);
      check_wen("R6 released", 1'b0, 1'b1);
      idle();
   endtask

   task automatic t_right_first_reads();
      drive(1'b0, 11'h000, 1'b0, 1'b1, 11'h3A0, 1'b0);
      tick();
      drive(1'b1, 11'h3A0, 1'b0, 1'b1, 11'h3A0, 1'b0);
      tick();
      check_busy("R2 R3 right first reads", 1'b0, 1'b1);
      check_wen("R2 reads", 1'b0, 1'b0);
      drive(1'b1, 11'h3A0, 1'b1, 1'b1, 11'h3A0, 1'b1);
      check_wen("R5 left blocked", 1'b0, 1'b1);
      tick();
      check_busy("R2 write bits ignored", 1'b0, 1'b1);
      drive(1'b1, 11'h3A0, 1'b1, 1'b1, 11'h3A1, 1'b1);
      tick();
      check_busy("R6 winner moved", 1'b1, 1'b1);
      check_wen("R6 winner moved", 1'b1, 1'b1);
      idle();
   endtask

   task automatic t_tie();
      drive(1'b1, 11'h7FF, 1'b1, 1'b1, 11'h7FF, 1'b1);
      check_wen("R4 tie decision", 1'b1, 1'b0);
      tick();
      check_busy("R4 tie left wins", 1'b1, 1'b0);
      tick();
      check_busy("R4 tie holds", 1'b1, 1'b0);
      idle();
      drive(1'b1, 11'h000, 1'b0, 1'b1, 11'h000, 1'b0);
      tick();
      check_busy("R4 tie at zero", 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_loser_returns();
      drive(1'b1, 11'h003, 1'b0, 1'b0, 11'h000, 1'b0);
      tick();
      drive(1'b1, 11'h003, 1'b0, 1'b1, 11'h003, 1'b1);
      tick();
      check_busy("R8 first loss", 1'b1, 1'b0);
      drive(1'b1, 11'h003, 1'b0, 1'b1, 11'h004, 1'b1);
      tick();
      check_busy("R8 loser away", 1'b1, 1'b1);
      drive(1'b1, 11'h003, 1'b0, 1'b1, 11'h003, 1'b1);
      check_wen("R8 return blocked", 1'b0, 1'b0);
      tick();
      check_busy("R8 loser back", 1'b1, 1'b0);
      idle();
   endtask

   task automatic t_slave();
      slave_mode = 1'b1;
      drive(1'b1, 11'h055, 1'b1, 1'b1, 11'h055, 1'b1);
      check_wen("R7 no busy inputs", 1'b1, 1'b1);
      tick();
      check_busy("R7 slave quiet", 1'b1, 1'b1);
      l_busy_in_n = 1'b0;
      #1;
      check_wen("R7 left inhibited", 1'b0, 1'b1);
      l_busy_in_n = 1'b1;
      r_busy_in_n = 1'b0;
      #1;
      check_wen("R7 right inhibited", 1'b1, 1'b0);
      tick();
      check_busy("R7 slave still quiet", 1'b1, 1'b1);
      r_busy_in_n = 1'b1;
      #1;
      check_wen("R7 inhibit lifted", 1'b1, 1'b1);
      idle();
      slave_mode = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_miss++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      tick();
      t_no_match();
      t_left_first();
      t_right_first_reads();
      t_tie();
      t_loser_returns();
      t_slave();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
      $finish;
   end
endmodule